// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block picks the divisor settings of a display clock synthesizer. Given a requested pixel clock in kHz and a select between two device families, it walks every combination of the first feedback divider (m1), the second feedback divider (m2), the reference divider (n) and the first post divider (p1). The second post divider (p2) is fixed by the size of the request. Each combination is screened against the family's range limits and the oscillator and output windows. Among those that pass, the engine keeps the one whose output frequency lands nearest the request.

A caller pulses `start_i` with the request on `target_i` and the family on `newer_i`. It then waits for the one-cycle `done_o` pulse. The result stays on the outputs until the next search completes. The outputs include each divisor on its own, the packed divisor word and the one-hot post-divider field. Candidates that fail the cheap range and window checks cost one cycle. Survivors pass through a shared shift-subtract divider that yields the exact output frequency.

Top module: `pll_divisor_search`

## Requirements
- R1: The output frequency of a candidate is floor(floor(96000*m/(n+2))/(p1*p2)) kHz, where m = 5*(m1+2)+(m2+2). The chosen candidate's error is computed from that value.
- R2: With `newer_i`=1 the limits are m1 10..20, m2 5..9, m 70..120 and n+2 3..8. With `newer_i`=0 they are m1 16..24, m2 7..11, m 90..130 and n+2 4..8.
- R3: A candidate qualifies only under all of these conditions: p1 is 1..8, p1+p2 is 5..80 and m1 > m2; the oscillator value floor(96000*m/(n+2)) is 1,400,000..2,800,000; and the output frequency is 20,000..400,000.
- R4: p2 is 10 when the request is below 200000 and 5 otherwise. `p2_o` reports the value used by the last completed search.
- R5: The sweep runs m1 from its minimum to its maximum (outermost), then m2 from its minimum to one below its maximum, then n from 1 to 6, then p1 from 1 to 8 (innermost). The running best error starts at the request. A candidate replaces the best only when its error is strictly smaller, so among equal errors the earliest one wins.
- R6: `found_o` is 1 exactly when the final best error differs from the request. When it is 0, `m1_o`, `m2_o`, `n_o`, `p1_o`, `div_word_o` and `p1_sel_o` are all zero.
- R7: `div_word_o` carries n in bits 23:16, m1 in bits 15:8 and m2 in bits 7:0. `p1_sel_o` has only bit p1-1 set, which is bit 16+p1-1 of the control word.
- R8: `busy_o` rises the cycle after an accepted `start_i` and falls with a single-cycle `done_o` pulse. A `start_i` that arrives while busy is ignored.
- R9: After reset every output is zero. Results change only on the cycle `done_o` is high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (ignored while busy) |
| target_i | input | 20 | Requested pixel clock in kHz |
| newer_i | input | 1 | Family select: 1 newer limits, 0 older limits |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A candidate better than the initial error exists |
| m1_o | output | 8 | Chosen first feedback divider |
| m2_o | output | 8 | Chosen second feedback divider |
| n_o | output | 8 | Chosen reference divider |
| p1_o | output | 4 | Chosen first post divider |
| p2_o | output | 4 | Second post divider applied |
| div_word_o | output | 24 | Packed n / m1 / m2 word |
| p1_sel_o | output | 8 | One-hot first post divider field |

## Verification
The bench aims at the p2 switch point by running requests of 199999 and 200000 kHz. A design with an off-by-one threshold would pick the wrong p2 and a different divisor set. Both families are swept, so swapped or shifted limit tables show up as divisors outside the expected set. A request too small for any candidate to beat must report not found with zeroed fields; a design that compares with less-or-equal, or that seeds the error wrongly, would report a spurious result. A restart pulse in the middle of a search must not change the target, and results must not move until the completion pulse. A design that lets the running best leak to the outputs, or that restarts on a busy start, would break both.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    localparam int FW = 8;

    typedef struct packed {
        logic [FW-1:0] m1_lo;
        logic [FW-1:0] m1_hi;
        logic [FW-1:0] m2_lo;
        logic [FW-1:0] m2_hi;
        logic [FW-1:0] m_lo;
        logic [FW-1:0] m_hi;
        logic [FW-1:0] np2_lo;
        logic [FW-1:0] np2_hi;
    } lim_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DIV  = 2'd2
    } st_e;

    function automatic lim_t family_limits(input logic newer);
        lim_t l;
        if (newer) begin
            l.m1_lo = 8'd10;  l.m1_hi = 8'd20;
            l.m2_lo = 8'd5;   l.m2_hi = 8'd9;
            l.m_lo  = 8'd70;  l.m_hi  = 8'd120;
            l.np2_lo = 8'd3;  l.np2_hi = 8'd8;
        end else begin
            l.m1_lo = 8'd16;  l.m1_hi = 8'd24;
            l.m2_lo = 8'd7;   l.m2_hi = 8'd11;
            l.m_lo  = 8'd90;  l.m_hi  = 8'd130;
            l.np2_lo = 8'd4;  l.np2_hi = 8'd8;
        end
        return l;
    endfunction

endpackage

// File: rtl/pll_srch_check.sv
module pll_srch_check
    import pll_srch_pkg::*;
#(
    parameter int unsigned REF_KHZ  = 96000,
    parameter int unsigned VCO_MIN  = 1400000,
    parameter int unsigned VCO_MAX  = 2800000,
    parameter int unsigned DOT_MIN  = 20000,
    parameter int unsigned DOT_MAX  = 400000,
    parameter int unsigned P1_LAST  = 8,
    parameter int unsigned PSUM_MIN = 5,
    parameter int unsigned PSUM_MAX = 80,
    parameter int          PW       = 4,
    parameter int          NUM_W    = 24,
    parameter int          DEN_W    = 10
) (
    input  lim_t              lim,
    input  logic [FW-1:0]     m1,
    input  logic [FW-1:0]     m2,
    input  logic [FW-1:0]     n,
    input  logic [PW-1:0]     p1,
    input  logic [PW-1:0]     p2,
    output logic              valid,
    output logic [NUM_W-1:0]  num,
    output logic [DEN_W-1:0]  den
);

    logic [31:0] m1w, m2w, p1w, p2w, mw, np2w, psum, numw, denw;

    always_comb begin
        m1w  = 32'(m1);
        m2w  = 32'(m2);
        p1w  = 32'(p1);
        p2w  = 32'(p2);
        mw   = 32'd5 * (m1w + 32'd2) + (m2w + 32'd2);
        np2w = 32'(n) + 32'd2;
        psum = p1w + p2w;
        numw = REF_KHZ * mw;
        denw = np2w * p1w * p2w;

        valid = (p1w >= 32'd1) && (p1w <= P1_LAST)
             && (psum >= PSUM_MIN) && (psum <= PSUM_MAX)
             && (m2w >= 32'(lim.m2_lo)) && (m2w <= 32'(lim.m2_hi))
             && (m1w >= 32'(lim.m1_lo)) && (m1w <= 32'(lim.m1_hi))
             && (m1w > m2w)
             && (mw >= 32'(lim.m_lo)) && (mw <= 32'(lim.m_hi))
             && (np2w >= 32'(lim.np2_lo)) && (np2w <= 32'(lim.np2_hi))
             // floor(num/np2) inside the oscillator window, without dividing
             && (numw >= VCO_MIN * np2w) && (numw < (VCO_MAX + 32'd1) * np2w)
             // floor(num/den) inside the output window, without dividing
             && (numw >= DOT_MIN * denw) && (numw < (DOT_MAX + 32'd1) * denw);

        num = numw[NUM_W-1:0];
        den = denw[DEN_W-1:0];
    end

endmodule

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 10,
    parameter int QW    = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [QW-1:0]    quo_o
);

    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [QW-1:0]    sh;
    } div_t;

    div_t d_d, d_q;
    logic [DEN_W:0] cat;
    logic           ge;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        cat      = {d_q.rem, d_q.sh[QW-1]};
        ge       = (cat >= {1'b0, d_q.den});
        if (start_i && !d_q.busy) begin
            // quotient fits QW bits, so the top bits alone are below den
            d_d.busy = 1'b1;
            d_d.cnt  = CW'(QW);
            d_d.rem  = DEN_W'(num_i[NUM_W-1:QW]);
            d_d.sh   = num_i[QW-1:0];
            d_d.den  = den_i;
        end else if (d_q.busy) begin
            d_d.rem = ge ? (cat[DEN_W-1:0] - d_q.den) : cat[DEN_W-1:0];
            d_d.sh  = {d_q.sh[QW-2:0], ge};
            d_d.cnt = d_q.cnt - CW'(1);
            if (d_q.cnt == CW'(1)) begin
                d_d.busy = 1'b0;
                d_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign done_o = d_q.done;
    assign quo_o  = d_q.sh;

    AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !d_q.busy); // R3
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.done |=> !d_q.done); // R3

endmodule

// File: rtl/pll_srch_fmt.sv
module pll_srch_fmt
    import pll_srch_pkg::*;
#(
    parameter int PW      = 4,
    parameter int P1_LAST = 8
) (
    input  logic [FW-1:0]     m1,
    input  logic [FW-1:0]     m2,
    input  logic [FW-1:0]     n,
    input  logic [PW-1:0]     p1,
    output logic [3*FW-1:0]   word,
    output logic [P1_LAST-1:0] p1_sel
);

    assign word = {n, m1, m2};

    for (genvar g = 0; g < P1_LAST; g++) begin : g_sel
        assign p1_sel[g] = (p1 == PW'(g + 1));
    end

endmodule

// File: rtl/pll_divisor_search.sv
module pll_divisor_search
    import pll_srch_pkg::*;
#(
    parameter int unsigned REF_KHZ       = 96000,
    parameter int unsigned VCO_MIN       = 1400000,
    parameter int unsigned VCO_MAX       = 2800000,
    parameter int unsigned DOT_MIN       = 20000,
    parameter int unsigned DOT_MAX       = 400000,
    parameter int unsigned P2_SWITCH_KHZ = 200000,
    parameter int unsigned P2_LOW        = 10,
    parameter int unsigned P2_HIGH       = 5,
    parameter int unsigned N_LAST        = 6,
    parameter int unsigned P1_LAST       = 8,
    parameter int unsigned M_CEIL        = 160,
    parameter int          TGT_W         = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TGT_W-1:0]   target_i,
    input  logic               newer_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               found_o,
    output logic [7:0]         m1_o,
    output logic [7:0]         m2_o,
    output logic [7:0]         n_o,
    output logic [3:0]         p1_o,
    output logic [3:0]         p2_o,
    output logic [23:0]        div_word_o,
    output logic [7:0]         p1_sel_o
);

    localparam int unsigned PMAX  = (P1_LAST > P2_LOW) ? P1_LAST : P2_LOW;
    localparam int          PW    = $clog2(PMAX + 1);
    localparam int          QW    = $clog2(DOT_MAX + 1);
    localparam int          NUM_W = $clog2(REF_KHZ * M_CEIL);
    localparam int          DEN_W = $clog2((N_LAST + 2) * P1_LAST * P2_LOW + 1);

    typedef struct packed {
        st_e              st;
        logic             busy;
        logic             done;
        logic             newer;
        logic [TGT_W-1:0] tgt;
        logic [PW-1:0]    p2;
        logic [FW-1:0]    m1;
        logic [FW-1:0]    m2;
        logic [FW-1:0]    n;
        logic [PW-1:0]    p1;
        logic [TGT_W-1:0] best_err;
        logic [FW-1:0]    b_m1;
        logic [FW-1:0]    b_m2;
        logic [FW-1:0]    b_n;
        logic [PW-1:0]    b_p1;
        logic             r_found;
        logic [FW-1:0]    r_m1;
        logic [FW-1:0]    r_m2;
        logic [FW-1:0]    r_n;
        logic [PW-1:0]    r_p1;
        logic [PW-1:0]    r_p2;
    } srch_t;

    srch_t s_d, s_q;

    lim_t             lim_run, lim_in;
    logic             cand_ok, div_go, div_done, adv;
    logic [NUM_W-1:0] cand_num;
    logic [DEN_W-1:0] cand_den;
    logic [QW-1:0]    div_quo;
    logic [TGT_W-1:0] dot_t, err;

    assign lim_run = family_limits(s_q.newer);
    assign lim_in  = family_limits(newer_i);

    pll_srch_check #(
        .REF_KHZ (REF_KHZ), .VCO_MIN (VCO_MIN), .VCO_MAX (VCO_MAX),
        .DOT_MIN (DOT_MIN), .DOT_MAX (DOT_MAX), .P1_LAST (P1_LAST),
        .PSUM_MIN(5), .PSUM_MAX(80), .PW(PW), .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) u_check (
        .lim  (lim_run),
        .m1   (s_q.m1),
        .m2   (s_q.m2),
        .n    (s_q.n),
        .p1   (s_q.p1),
        .p2   (s_q.p2),
        .valid(cand_ok),
        .num  (cand_num),
        .den  (cand_den)
    );

    pll_srch_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QW(QW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_go),
        .num_i  (cand_num),
        .den_i  (cand_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        dot_t = TGT_W'(div_quo);
        err   = (dot_t > s_q.tgt) ? (dot_t - s_q.tgt) : (s_q.tgt - dot_t);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        div_go   = 1'b0;
        adv      = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st       = ST_EVAL;
                    s_d.busy     = 1'b1;
                    s_d.newer    = newer_i;
                    s_d.tgt      = target_i;
                    s_d.p2       = (target_i < TGT_W'(P2_SWITCH_KHZ)) ? PW'(P2_LOW) : PW'(P2_HIGH);
                    s_d.m1       = lim_in.m1_lo;
                    s_d.m2       = lim_in.m2_lo;
                    s_d.n        = FW'(1);
                    s_d.p1       = PW'(1);
                    s_d.best_err = target_i;
                    s_d.b_m1     = '0;
                    s_d.b_m2     = '0;
                    s_d.b_n      = '0;
                    s_d.b_p1     = '0;
                end
            end
            ST_EVAL: begin
                if (cand_ok) begin
                    div_go = 1'b1;
                    s_d.st = ST_DIV;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    if (err < s_q.best_err) begin
                        s_d.best_err = err;
                        s_d.b_m1     = s_q.m1;
                        s_d.b_m2     = s_q.m2;
                        s_d.b_n      = s_q.n;
                        s_d.b_p1     = s_q.p1;
                    end
                    adv = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (adv) begin
            s_d.st = ST_EVAL;
            if (s_q.p1 != PW'(P1_LAST)) begin
                s_d.p1 = s_q.p1 + PW'(1);
            end else begin
                s_d.p1 = PW'(1);
                if (s_q.n != FW'(N_LAST)) begin
                    s_d.n = s_q.n + FW'(1);
                end else begin
                    s_d.n = FW'(1);
                    if (s_q.m2 != lim_run.m2_hi - FW'(1)) begin
                        s_d.m2 = s_q.m2 + FW'(1);
                    end else begin
                        s_d.m2 = lim_run.m2_lo;
                        if (s_q.m1 != lim_run.m1_hi) begin
                            s_d.m1 = s_q.m1 + FW'(1);
                        end else begin
                            s_d.st      = ST_IDLE;
                            s_d.busy    = 1'b0;
                            s_d.done    = 1'b1;
                            s_d.r_found = (s_d.best_err != s_q.tgt);
                            s_d.r_m1    = s_d.b_m1;
                            s_d.r_m2    = s_d.b_m2;
                            s_d.r_n     = s_d.b_n;
                            s_d.r_p1    = s_d.b_p1;
                            s_d.r_p2    = s_q.p2;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = s_q.busy;
    assign done_o  = s_q.done;
    assign found_o = s_q.r_found;
    assign m1_o    = s_q.r_m1;
    assign m2_o    = s_q.r_m2;
    assign n_o     = s_q.r_n;
    assign p1_o    = s_q.r_p1;
    assign p2_o    = s_q.r_p2;

    pll_srch_fmt #(.PW(PW), .P1_LAST(P1_LAST)) u_fmt (
        .m1    (s_q.r_m1),
        .m2    (s_q.r_m2),
        .n     (s_q.r_n),
        .p1    (s_q.r_p1),
        .word  (div_word_o),
        .p1_sel(p1_sel_o)
    );

    AST_DOT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (div_quo >= QW'(DOT_MIN)) && (div_quo <= QW'(DOT_MAX))); // R3
    AST_FOUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.r_found |-> (s_q.r_m1 > s_q.r_m2)); // R3
    AST_FOUND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.r_found |-> ($countones(p1_sel_o) == 1)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> $stable(s_q.tgt)); // R8
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.done |-> $stable({s_q.r_found, s_q.r_m1, s_q.r_m2, s_q.r_n, s_q.r_p1, s_q.r_p2})); // R9

endmodule

// File: tb/test_pll_divisor_search.sv
module test_pll_divisor_search;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] target_i = '0;
    logic        newer_i = 1'b0;
    logic        busy_o, done_o, found_o;
    logic [7:0]  m1_o, m2_o, n_o, p1_sel_o;
    logic [3:0]  p1_o, p2_o;
    logic [23:0] div_word_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    // reference expectations: current (what outputs must show) and next
    int cur_found = 0, cur_m1 = 0, cur_m2 = 0, cur_n = 0, cur_p1 = 0, cur_p2 = 0;
    int nxt_found = 0, nxt_m1 = 0, nxt_m2 = 0, nxt_n = 0, nxt_p1 = 0, nxt_p2 = 0, nxt_dot = 0;
    bit hold_bad = 0;

    pll_divisor_search i_pll_divisor_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .newer_i(newer_i), .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .m1_o(m1_o), .m2_o(m2_o), .n_o(n_o), .p1_o(p1_o), .p2_o(p2_o),
        .div_word_o(div_word_o), .p1_sel_o(p1_sel_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dot_of(input int m1, input int m2, input int n,
                                  input int p1, input int p2);
        int m = 5 * (m1 + 2) + (m2 + 2);
        int vco = 96000 * m / (n + 2);
        return vco / (p1 * p2);
    endfunction

    // behavioural reference of the whole search
    task automatic model(input int tgt, input bit newer);
        int m1lo, m1hi, m2lo, m2hi, mlo, mhi, nlo, p2, err;
        m1lo = newer ? 10 : 16;  m1hi = newer ? 20 : 24;
        m2lo = newer ? 5 : 7;    m2hi = newer ? 9 : 11;
        mlo  = newer ? 70 : 90;  mhi  = newer ? 120 : 130;
        nlo  = newer ? 3 : 4;
        p2   = (tgt < 200000) ? 10 : 5;
        err  = tgt;
        nxt_m1 = 0; nxt_m2 = 0; nxt_n = 0; nxt_p1 = 0; nxt_dot = 0;
        for (int a = m1lo; a <= m1hi; a++)
            for (int b = m2lo; b < m2hi; b++)
                for (int c = 1; c <= 6; c++)
                    for (int d = 1; d <= 8; d++) begin
                        int m = 5 * (a + 2) + (b + 2);
                        int vco = 96000 * m / (c + 2);
                        int dot = vco / (d * p2);
                        int e;
                        if (d + p2 < 5 || d + p2 > 80) continue;
                        if (a <= b) continue;
                        if (m < mlo || m > mhi) continue;
                        if (c + 2 < nlo || c + 2 > 8) continue;
                        if (vco < 1400000 || vco > 2800000) continue;
                        if (dot < 20000 || dot > 400000) continue;
                        e = (dot > tgt) ? dot - tgt : tgt - dot;
                        if (e < err) begin
                            err = e; nxt_m1 = a; nxt_m2 = b; nxt_n = c; nxt_p1 = d; nxt_dot = dot;
                        end
                    end
        nxt_found = (err != tgt) ? 1 : 0;
        nxt_p2 = p2;
    endtask

    // per-clock comparison against the reference; outputs may only move with done
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                cur_found = nxt_found; cur_m1 = nxt_m1; cur_m2 = nxt_m2;
                cur_n = nxt_n; cur_p1 = nxt_p1; cur_p2 = nxt_p2;
            end
            if (int'(found_o) != cur_found || int'(m1_o) != cur_m1 || int'(m2_o) != cur_m2 ||
                int'(n_o) != cur_n || int'(p1_o) != cur_p1 || int'(p2_o) != cur_p2)
                hold_bad = 1;
        end
    end

    task automatic run_search(input int tgt, input bit newer, input bit poke);
        int exp_sel, exp_word;
        model(tgt, newer);
        hold_bad = 0;
        @(negedge clk);
        start_i = 1'b1; target_i = 20'(tgt); newer_i = newer;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
        if (poke) begin
            repeat (50) @(negedge clk);
            start_i = 1'b1; target_i = 20'd333333; newer_i = ~newer;
            @(negedge clk);
            start_i = 1'b0; target_i = 20'(tgt);
        end
        while (!done_o) @(negedge clk);
        check(busy_o == 1'b0, "R8", "busy falls with done", int'(busy_o), 0);
        check(int'(found_o) == nxt_found, "R6", "found", int'(found_o), nxt_found);
        check(int'(p2_o) == nxt_p2, "R4", "p2", int'(p2_o), nxt_p2);
        check(int'(m1_o) == nxt_m1, "R5", "m1", int'(m1_o), nxt_m1);
        check(int'(m2_o) == nxt_m2, "R5", "m2", int'(m2_o), nxt_m2);
        check(int'(n_o) == nxt_n, "R5", "n", int'(n_o), nxt_n);
        check(int'(p1_o) == nxt_p1, "R5", "p1", int'(p1_o), nxt_p1);
        exp_word = (nxt_n << 16) | (nxt_m1 << 8) | nxt_m2;
        check(int'(div_word_o) == exp_word, "R7", "packed word", int'(div_word_o), exp_word);
        exp_sel = (nxt_found != 0) ? (1 << (nxt_p1 - 1)) : 0;
        check(int'(p1_sel_o) == exp_sel, "R7", "p1 one-hot", int'(p1_sel_o), exp_sel);
        if (nxt_found != 0) begin
            int d = dot_of(int'(m1_o), int'(m2_o), int'(n_o), int'(p1_o), int'(p2_o));
            int mm = 5 * (int'(m1_o) + 2) + (int'(m2_o) + 2);
            int vc = 96000 * mm / (int'(n_o) + 2);
            check(d == nxt_dot, "R1", "synthesized frequency", d, nxt_dot);
            check(newer ? (m1_o >= 10 && m1_o <= 20 && mm >= 70 && mm <= 120)
                        : (m1_o >= 16 && m1_o <= 24 && mm >= 90 && mm <= 130),
                  "R2", "family limit on m", mm, 0);
            check(m1_o > m2_o && vc >= 1400000 && vc <= 2800000 && d >= 20000 && d <= 400000,
                  "R3", "oscillator window", vc, 0);
        end else begin
            check(int'(m1_o) == 0 && int'(n_o) == 0, "R6", "zero fields when not found",
                  int'(m1_o) + int'(n_o), 0);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R8", "done is one cycle", int'(done_o), 0);
        check(hold_bad == 0, "R9", "outputs held outside done", int'(hold_bad), 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual %0d expected done", WATCHDOG_CYCLES);
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R9", "reset handshake", int'(busy_o), 0);
        check(found_o == 1'b0 && p2_o == 4'd0, "R9", "reset result", int'(found_o), 0);
        check(div_word_o == 24'd0 && p1_sel_o == 8'd0, "R9", "reset fields", int'(div_word_o), 0);
        run_search(65000, 1'b1, 1'b1);   // mid-run start must be ignored (R8)
        run_search(199999, 1'b0, 1'b0);  // just below the p2 switch (R4)
        run_search(200000, 1'b1, 1'b0);  // at the p2 switch (R4)
        run_search(5, 1'b0, 1'b0);       // nothing can beat the seed error (R6)
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule